// File: doc/BRIEF.md
# Peripheral Request-to-Channel Router

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. Every request line owns one mapping register. The register holds an enable flag and a target channel number. The block first synchronises each incoming request. It then steers the request onto the request output of the channel named in that line's mapping. Software programs and inspects the mappings through a simple word-wide register port. Request lines with numbers 64 and above use a second address window.

Several request lines may name the same channel. In that case the channel sees the OR of all of them. A line whose mapping is disabled reaches no channel. Writing zero to a mapping register detaches its request line. The block does no arbitration between channels; it only routes requests.

Top module: `dreq_router`

## Requirements
- R1: After reset every mapping reads as zero, every channel request output is low and the read data bus is zero.
- R2: A mapping register keeps bit 7 (enable flag) and bits 4:0 (channel number) of the last accepted write. All other bits of a read return zero.
- R3: The mapping for request line n below 64 sits at byte address 0x0100 + 4*n.
- R4: The mapping for request line n of 64 or above sits at byte address 0x1100 + 4*(n-64). It does not alias any mapping of the lower window.
- R5: An asserted request line whose mapping has the enable flag set drives the request output of the channel given by its channel number.
- R6: A request line whose mapping has the enable flag clear reaches no channel. Writing zero to an enabled mapping removes the route.
- R7: When several asserted request lines map to the same channel, that channel's output is their OR. It stays high while any of them is asserted.
- R8: A request line reaches at most one channel. Rewriting its mapping moves the request from the old channel to the new one.
- R9: A write to an address that is misaligned, outside both windows, or beyond the last request line changes no mapping. A read of such an address returns zero.
- R10: A change on a request input reaches the channel outputs exactly two clock cycles later, for both assertion and deassertion.
- R11: Read data appears on the cycle after the read strobe. In every cycle that does not follow a read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (16) | Byte address of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid the cycle after reg_rd_en |
| req_in | input | NUM_REQ (80) | Peripheral request lines, asynchronous |
| ch_req_out | output | NUM_CH (32) | Routed request to each channel |

## Verification
A corrupted mapping register shows up two ways. Its request appears on the wrong channel output, or it is missing, two cycles after the request is applied. The same fault is also visible on reg_rdata one cycle after a read of that register. An address-decode fault lands a write in the wrong slot. Reading back a neighbouring slot or the other window exposes it at once. A synchroniser depth error moves every output edge by one cycle. The bench samples after the first edge and after the second edge, so such a shift is caught.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

  localparam int unsigned LO_BASE   = 32'h0000_0100;
  localparam int unsigned HI_BASE   = 32'h0000_1100;
  localparam int unsigned WIN_SLOTS = 64;
  localparam int unsigned CH_BITS   = 5;

  typedef struct packed {
    logic               vld;
    logic [CH_BITS-1:0] ch;
  } map_t;

  localparam int unsigned MAP_W = $bits(map_t);

  typedef struct packed {
    logic        hit;
    logic [15:0] idx;
  } slot_t;

  // Pack a mapping into its 8-bit register view: enable at bit 7, channel at 4:0.
  function automatic logic [7:0] map_to_word(input map_t m);
    return {m.vld, 2'b00, m.ch};
  endfunction

  function automatic map_t word_to_map(input logic [7:0] w);
    map_t m;
    m.vld = w[7];
    m.ch  = w[CH_BITS-1:0];
    return m;
  endfunction

  // Byte address to mapping slot; two windows of 64 word slots each.
  function automatic slot_t decode_slot(input logic [31:0] a, input int unsigned nreq);
    slot_t       s;
    logic [31:0] off;
    s   = '0;
    off = '0;
    if (a[1:0] == 2'b00) begin
      if (a >= LO_BASE && a < LO_BASE + 4 * WIN_SLOTS) begin
        off = (a - LO_BASE) >> 2;
        s.hit = (off < nreq);
      end else if (a >= HI_BASE && a < HI_BASE + 4 * WIN_SLOTS) begin
        off = WIN_SLOTS + ((a - HI_BASE) >> 2);
        s.hit = (off < nreq);
      end
    end
    s.idx = s.hit ? off[15:0] : 16'd0;
    return s;
  endfunction

  // True when mapping m steers its request onto channel c.
  function automatic logic routes_to(input map_t m, input int unsigned c);
    return m.vld && (32'(m.ch) == c);
  endfunction

endpackage

// File: rtl/dreq_router_decode.sv
module dreq_router_decode
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned ADDR_W  = 16,
  localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  slot_t slot;
  logic  unused_idx_hi;

  always_comb begin
    slot = decode_slot(32'(addr), NUM_REQ);
    hit  = slot.hit;
    idx  = slot.idx[IDX_W-1:0];
  end

  assign unused_idx_hi = ^slot.idx;

endmodule

// File: rtl/dreq_router_maps.sv
module dreq_router_maps
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     acc_hit,
  input  logic [IDX_W-1:0]         acc_idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_REQ*MAP_W-1:0] map_flat
);

  map_t       map_q [NUM_REQ];
  logic [7:0] rd_word;
  logic       unused_wbits;

  for (genvar n = 0; n < NUM_REQ; n++) begin : g_slot
    logic sel;
    assign sel = wr_en && acc_hit && (acc_idx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[n] <= '0;
      end else if (sel) begin
        map_q[n] <= word_to_map(wdata[7:0]);
      end
    end

    assign map_flat[n*MAP_W +: MAP_W] = map_q[n];
  end

  always_comb begin
    rd_word = 8'h00;
    if (acc_hit && (32'(acc_idx) < NUM_REQ)) begin
      rd_word = map_to_word(map_q[acc_idx]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= {{(DATA_W-8){1'b0}}, rd_word};
    end else begin
      rdata <= '0;
    end
  end

  assign unused_wbits = ^{wdata[DATA_W-1:8], wdata[6:5]};

endmodule

// File: rtl/dreq_router_sync.sv
module dreq_router_sync #(
  parameter int unsigned WIDTH  = 80,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= d;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/dreq_router_route.sv
module dreq_router_route
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic [NUM_REQ-1:0]       req,
  input  logic [NUM_REQ*MAP_W-1:0] map_flat,
  output logic [NUM_CH-1:0]        ch_req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      ch_req[c] = 1'b0;
      for (int n = 0; n < NUM_REQ; n++) begin
        if (req[n] && routes_to(map_t'(map_flat[n*MAP_W +: MAP_W]), c)) begin
          ch_req[c] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  ch_req_out
);

  localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic                     acc_hit;
  logic [IDX_W-1:0]         acc_idx;
  logic [NUM_REQ*MAP_W-1:0] map_flat;
  logic [NUM_REQ-1:0]       req_sync;

  dreq_router_decode #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_decode (
    .addr (reg_addr),
    .hit  (acc_hit),
    .idx  (acc_idx)
  );

  dreq_router_maps #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_maps (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .acc_hit  (acc_hit),
    .acc_idx  (acc_idx),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .map_flat (map_flat)
  );

  dreq_router_sync #(.WIDTH(NUM_REQ), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_in),
    .q     (req_sync)
  );

  dreq_router_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .req      (req_sync),
    .map_flat (map_flat),
    .ch_req   (ch_req_out)
  );

endmodule

// File: rtl/dreq_router_chk.sv
module dreq_router_chk
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned DATA_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr_en,
  input logic                     reg_rd_en,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic [NUM_REQ-1:0]       req_in,
  input logic [NUM_CH-1:0]        ch_req_out,
  input logic                     acc_hit,
  input logic [NUM_REQ*MAP_W-1:0] map_flat,
  input logic [NUM_REQ-1:0]       req_sync
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  // R2
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DATA_W-1:8] == '0) && (reg_rdata[6:5] == 2'b00));

  // R11
  a_r11_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> (reg_rdata == '0));

  // R9
  a_r9_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !acc_hit) |=> $stable(map_flat));

  // R10
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == 2'd2) && (ch_req_out != '0)) |-> ($past(req_in, 2) != '0));

  // R5
  for (genvar n = 0; n < NUM_REQ; n++) begin : g_req
    map_t m;
    assign m = map_t'(map_flat[n*MAP_W +: MAP_W]);
    a_r5_route: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sync[n] && m.vld && (32'(m.ch) < NUM_CH)) |-> ch_req_out[m.ch]);
  end

endmodule

bind dreq_router dreq_router_chk #(
  .NUM_REQ (NUM_REQ),
  .NUM_CH  (NUM_CH),
  .DATA_W  (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_rdata  (reg_rdata),
  .req_in     (req_in),
  .ch_req_out (ch_req_out),
  .acc_hit    (acc_hit),
  .map_flat   (map_flat),
  .req_sync   (req_sync)
);

// File: tb/dreq_router_tb.sv
module dreq_router_tb;

  localparam int NREQ = 80;
  localparam int NCH  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr_en = 1'b0;
  logic            reg_rd_en = 1'b0;
  logic [15:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NREQ-1:0] req_in = '0;
  logic [NCH-1:0]  ch_req_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [NREQ];

  always #4 clk = ~clk;

  dreq_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_in(req_in), .ch_req_out(ch_req_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] slot_addr(input int n);
    return (n < 64) ? 16'(32'h100 + 4*n) : 16'(32'h1100 + 4*(n-64));
  endfunction

  function automatic logic [NCH-1:0] expect_out(input logic [NREQ-1:0] v);
    logic [NCH-1:0] o = '0;
    for (int n = 0; n < NREQ; n++)
      if (v[n] && mdl[n][7]) o[mdl[n][4:0]] = 1'b1;
    return o;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic wr_map(input int n, input logic [31:0] d);
    wr(slot_addr(n), d);
    mdl[n] = d[7:0] & 8'h9F;
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_rd_en = 1'b1;
    step();
    reg_rd_en = 1'b0;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic drive_check(input logic [NREQ-1:0] v, input string tag);
    logic [NCH-1:0] e;
    req_in = v;
    step(); step();
    e = expect_out(v);
    check(ch_req_out == e, tag, 64'(ch_req_out), 64'(e));
  endtask

  task automatic t_reset();
    check(ch_req_out == '0, "R1 outputs", 64'(ch_req_out), 0);
    check(reg_rdata == '0, "R1 rdata", 64'(reg_rdata), 0);
    rd_check(slot_addr(0), 0, "R1 map0");
    rd_check(slot_addr(NREQ-1), 0, "R1 map last");
  endtask

  task automatic t_regs();
    wr_map(3, 32'hFFFF_FF9A);
    rd_check(slot_addr(3), 32'h9A, "R2 field mask");
    wr_map(63, 32'h0000_0085);
    rd_check(16'h01FC, 32'h85, "R3 low window top");
    wr_map(64, 32'h0000_0091);
    rd_check(16'h1100, 32'h91, "R4 high window base");
    rd_check(16'h0100, 32'h00, "R4 no alias low");
    wr_map(79, 32'h0000_009F);
    rd_check(16'h113C, 32'h9F, "R4 high window top");
  endtask

  task automatic t_route_latency();
    logic [NREQ-1:0] v = '0;
    wr_map(5, 32'h89);
    v[5] = 1'b1;
    req_in = v;
    step();
    check(ch_req_out == '0, "R10 not after one edge", 64'(ch_req_out), 0);
    step();
    check(ch_req_out == 32'h200, "R5 R10 ch9 after two edges", 64'(ch_req_out), 64'h200);
    req_in = '0;
    step();
    check(ch_req_out == 32'h200, "R10 hold one edge after drop", 64'(ch_req_out), 64'h200);
    step();
    check(ch_req_out == '0, "R10 drop after two edges", 64'(ch_req_out), 0);
    wr_map(70, 32'h9F);
    v = '0; v[70] = 1'b1;
    drive_check(v, "R5 high line to ch31");
    req_in = '0; step(); step();
  endtask

  task automatic t_or_move();
    logic [NREQ-1:0] v = '0;
    wr_map(1, 32'h84);
    wr_map(2, 32'h84);
    v[1] = 1'b1; v[2] = 1'b1;
    drive_check(v, "R7 two lines ch4");
    v[1] = 1'b0;
    drive_check(v, "R7 one line still ch4");
    wr_map(5, 32'h8C);
    v = '0; v[5] = 1'b1;
    drive_check(v, "R8 moved to ch12");
    check(ch_req_out[9] == 1'b0, "R8 old ch9 clear", 64'(ch_req_out[9]), 0);
    req_in = '0; step(); step();
  endtask

  task automatic t_disable();
    logic [NREQ-1:0] v = '0;
    wr_map(10, 32'h06);
    v[10] = 1'b1;
    drive_check(v, "R6 disabled map");
    check(ch_req_out == '0, "R6 nothing routed", 64'(ch_req_out), 0);
    req_in = '0;
    wr_map(10, 32'h86);
    drive_check(v, "R6 enabled ch6");
    req_in = '0;
    wr_map(10, 32'h0);
    drive_check(v, "R6 removed by zero write");
    check(ch_req_out == '0, "R6 removed nothing routed", 64'(ch_req_out), 0);
    req_in = '0; step(); step();
  endtask

  task automatic t_bad_addr();
    wr(16'h0102, 32'h85);
    wr(16'h0300, 32'h85);
    wr(16'h1140, 32'h85);
    wr(16'h1000, 32'h85);
    rd_check(16'h0102, 0, "R9 misaligned read");
    rd_check(16'h1140, 0, "R9 beyond last read");
    rd_check(slot_addr(0), 0, "R9 slot0 untouched");
    rd_check(slot_addr(16), 0, "R9 slot16 untouched");
    drive_check('1, "R9 all lines vs model");
    req_in = '0; step(); step();
  endtask

  task automatic t_rd_timing();
    reg_addr = slot_addr(3); reg_rd_en = 1'b1;
    check(reg_rdata == 0, "R11 not before edge", 64'(reg_rdata), 0);
    step();
    reg_rd_en = 1'b0;
    check(reg_rdata == 32'h9A, "R11 data after edge", 64'(reg_rdata), 64'h9A);
    step();
    check(reg_rdata == 0, "R11 zero when idle", 64'(reg_rdata), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < NREQ; n++) mdl[n] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_route_latency();
    t_or_move();
    t_disable();
    t_bad_addr();
    t_rd_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule